// File: doc/BRIEF.md
# Winner-Takes-All Disparity Selector with Left-Right Consistency

This block sits at the end of a semi-global stereo pipeline. Each clock it may accept one vector of aggregated costs, one cost per candidate disparity, for the next pixel of the base image in raster order. Line boundaries are marked on the input with a first-pixel flag and a last-pixel flag. For every base pixel it picks the disparity with the lowest cost. From the same stream of cost vectors it also derives the disparity of the other image of the pair, so no second aggregation pass is needed. It then emits each base disparity once it has passed a left-right consistency test.

The disparity of the other image at column x' is the index d that minimises S(x'+d, d). A row of running-minimum registers finds it. Each register follows one column of the other image. Each pixel that arrives updates every register with the cost for that register's disparity, and then the row moves one place to the right. A column is finished when it leaves the last register. So one disparity of the other image comes out per processed pixel. At the end of a line the block runs NDISP-1 internal padding cycles to finish the columns near the right edge. The sender must leave those cycles idle. A base disparity Db at column x is compared with the other image's disparity at column x-Db. Results leave in pixel order, one per base pixel.

Top module: `wta_lr_disparity`

## Requirements
- R1: The base disparity of a pixel is the index of its smallest cost among the NDISP candidates. Cost d sits at bits [d*CW +: CW] of the input vector. On a tie the smallest index wins.
- R2: The other image's disparity at column x' is the smallest d that minimises S(x'+d, d). Only candidates with x'+d inside the current line are used. Costs from earlier lines have no effect.
- R3: A pixel at column x with base disparity Db is accepted (out_ok = 1, out_disp = Db) only if x-Db >= 0 and |Db - other(x-Db)| <= 1.
- R4: A rejected pixel gives out_disp = NDISP (the reserved code) with out_ok = 0.
- R5: Each input line of W pixels (W >= 1) gives exactly W results, in column order. After a last-pixel input, in_valid must stay low for NDISP-1 cycles while the block pads the line.
- R6: While rst is high and in the first cycle after it, out_valid and out_ok are 0. After reset, out_disp is 0.
- R7: Idle cycles (in_valid low) inside a line do not change any result.
- R8: out_ok is high only together with out_valid. out_disp holds its value in cycles where out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Cost vector present this cycle |
| in_sol | input | 1 | Vector is the first pixel of a line |
| in_eol | input | 1 | Vector is the last pixel of a line |
| in_cost | input | NDISP*CW | Aggregated costs, disparity d at bits [d*CW +: CW] |
| out_valid | output | 1 | One result present this cycle |
| out_disp | output | DW | Accepted disparity, or NDISP when rejected |
| out_ok | output | 1 | Result passed the consistency test |

## Verification
The corners that are hardest to reach from the ports are the line edges. On the left edge, a base pixel points to a column before zero. On the right edge, the other image's search is cut short by the line end, so ties between padded and real candidates must fall back to the smallest index. A further corner is the exact boundary between a difference of 1 (accepted) and 2 (rejected). Random costs drawn from a narrow range of values produce frequent ties and near-equal disparities. Lines as short as one pixel, or shorter than NDISP, put most pixels on an edge. Lines built from a known disparity profile drive the accepted path, and random idle cycles inside lines test that gaps do not matter.

// File: rtl/wta_lr_pkg.sv
package wta_lr_pkg;
  // Width of a disparity code that can also carry the reserved value ndisp.
  function automatic int disp_bits(input int ndisp);
    return (ndisp < 2) ? 1 : $clog2(ndisp + 1);
  endfunction

  // Column counter width: a full line plus the padding cycles.
  function automatic int col_bits(input int line_max, input int ndisp);
    return $clog2(line_max + ndisp + 1);
  endfunction
endpackage

// File: rtl/wta_argmin.sv
module wta_argmin #(
  parameter int NDISP = 16,
  parameter int CW    = 10,
  parameter int DW    = 5
) (
  input  logic [NDISP*CW-1:0] costs,
  output logic [DW-1:0]       idx
);
  logic [CW-1:0] best;

  // Linear scan; strict compare keeps the lowest index on ties.
  always_comb begin
    best = costs[CW-1:0];
    idx  = '0;
    for (int d = 1; d < NDISP; d++) begin
      if (costs[d*CW +: CW] < best) begin
        best = costs[d*CW +: CW];
        idx  = DW'(d);
      end
    end
  end
endmodule

// File: rtl/match_min_array.sv
module match_min_array #(
  parameter int NDISP = 16,
  parameter int CW    = 10,
  parameter int DW    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  input  logic                restart,
  input  logic                pad,
  input  logic [NDISP*CW-1:0] costs,
  output logic [DW-1:0]       fin_idx
);
  localparam int EW = CW + 1;
  localparam logic [EW-1:0] INF = {1'b1, {CW{1'b0}}};

  logic [EW-1:0] r_cost [NDISP];
  logic [DW-1:0] r_idx  [NDISP];
  logic [EW-1:0] n_cost [NDISP];
  logic [DW-1:0] n_idx  [NDISP];

  // Slot d tracks the other-image column (current column - d).
  for (genvar d = 0; d < NDISP; d++) begin : g_slot
    logic [EW-1:0] held_c;
    logic [DW-1:0] held_i;
    logic [EW-1:0] cand;
    logic          take_new;
    assign held_c   = restart ? INF : r_cost[d];
    assign held_i   = restart ? '0  : r_idx[d];
    assign cand     = pad ? INF : {1'b0, costs[d*CW +: CW]};
    assign take_new = cand < held_c;
    assign n_cost[d] = take_new ? cand : held_c;
    assign n_idx[d]  = take_new ? DW'(d) : held_i;
  end

  assign fin_idx = n_idx[NDISP-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < NDISP; d++) begin
        r_cost[d] <= INF;
        r_idx[d]  <= '0;
      end
    end else if (step) begin
      r_cost[0] <= INF;
      r_idx[0]  <= '0;
      for (int d = 1; d < NDISP; d++) begin
        r_cost[d] <= n_cost[d-1];
        r_idx[d]  <= n_idx[d-1];
      end
    end
  end
endmodule

// File: rtl/lr_consistency.sv
module lr_consistency #(
  parameter int NDISP = 16,
  parameter int DW    = 5,
  parameter int XW    = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          emit,
  input  logic [DW-1:0] base_idx,
  input  logic [DW-1:0] match_idx,
  input  logic [XW-1:0] xpos,
  output logic          out_valid,
  output logic [DW-1:0] out_disp,
  output logic          out_ok
);
  logic [DW-1:0] bd [NDISP];   // base disparities, bd[k] = column c-k
  logic [DW-1:0] mh [NDISP];   // finished other-image disparities, newest first
  logic          bval;
  logic [XW-1:0] xb;
  logic [DW-1:0] db, dm, diff;
  logic          good;

  always_comb begin
    db = bd[NDISP-1];
    dm = '0;
    for (int k = 0; k < NDISP; k++)
      if (db == DW'(k)) dm = mh[k];
    diff = (db >= dm) ? db - dm : dm - db;
    good = (XW'(db) <= xb) && (diff <= DW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NDISP; k++) begin
        bd[k] <= '0;
        mh[k] <= '0;
      end
      bval      <= 1'b0;
      xb        <= '0;
      out_valid <= 1'b0;
      out_disp  <= '0;
      out_ok    <= 1'b0;
    end else begin
      if (step) begin
        for (int k = NDISP-1; k > 0; k--) bd[k] <= bd[k-1];
        bd[0] <= base_idx;
      end
      if (step && emit) begin
        for (int k = NDISP-1; k > 0; k--) mh[k] <= mh[k-1];
        mh[0] <= match_idx;
      end
      bval      <= step && emit;
      xb        <= xpos;
      out_valid <= bval;
      out_ok    <= bval && good;
      if (bval) out_disp <= good ? db : DW'(NDISP);
    end
  end
endmodule

// File: rtl/wta_lr_disparity.sv
module wta_lr_disparity
  import wta_lr_pkg::*;
#(
  parameter int NDISP    = 16,
  parameter int CW       = 10,
  parameter int LINE_MAX = 2048,
  localparam int DW      = disp_bits(NDISP),
  localparam int XW      = col_bits(LINE_MAX, NDISP)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_sol,
  input  logic                in_eol,
  input  logic [NDISP*CW-1:0] in_cost,
  output logic                out_valid,
  output logic [DW-1:0]       out_disp,
  output logic                out_ok
);
  logic [XW-1:0] col, cur, xpos;
  logic [DW-1:0] fl_cnt;
  logic          flushing, take, step, restart, emit;
  logic [DW-1:0] base_idx, match_idx;

  assign flushing = (fl_cnt != '0);
  assign take     = in_valid && !flushing;
  assign step     = take || flushing;
  assign restart  = take && in_sol;
  assign cur      = restart ? '0 : col;
  assign emit     = cur >= XW'(NDISP-1);
  assign xpos     = cur - XW'(NDISP-1);

  always_ff @(posedge clk) begin
    if (rst) begin
      col    <= '0;
      fl_cnt <= '0;
    end else begin
      if (step) col <= cur + XW'(1);
      if (take && in_eol) fl_cnt <= DW'(NDISP-1);
      else if (flushing)  fl_cnt <= fl_cnt - DW'(1);
    end
  end

  wta_argmin #(.NDISP(NDISP), .CW(CW), .DW(DW)) u_base (
    .costs (in_cost),
    .idx   (base_idx)
  );

  match_min_array #(.NDISP(NDISP), .CW(CW), .DW(DW)) u_match (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .restart (restart),
    .pad     (flushing),
    .costs   (in_cost),
    .fin_idx (match_idx)
  );

  lr_consistency #(.NDISP(NDISP), .DW(DW), .XW(XW)) u_check (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .emit      (emit),
    .base_idx  (base_idx),
    .match_idx (match_idx),
    .xpos      (xpos),
    .out_valid (out_valid),
    .out_disp  (out_disp),
    .out_ok    (out_ok)
  );
endmodule

// File: rtl/wta_lr_disparity_chk.sv
module wta_lr_disparity_chk #(
  parameter int NDISP = 16,
  parameter int DW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_eol,
  input logic          out_valid,
  input logic [DW-1:0] out_disp,
  input logic          out_ok,
  input logic          flushing
);
  a_r4_reject_code: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ok) |-> (out_disp == DW'(NDISP)));

  a_r3_accept_range: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ok) |-> (out_disp < DW'(NDISP)));

  a_r6_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_ok));

  a_r8_ok_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_ok |-> out_valid);

  a_r8_hold_disp: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_disp));

  a_r5_pad_idle: assert property (@(posedge clk) disable iff (rst)
    flushing |-> !in_valid);

  if (NDISP > 1) begin : g_gap
    a_r5_gap_after_eol: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_eol && !flushing) |=> !in_valid);
  end
endmodule

bind wta_lr_disparity wta_lr_disparity_chk #(.NDISP(NDISP), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_eol    (in_eol),
  .out_valid (out_valid),
  .out_disp  (out_disp),
  .out_ok    (out_ok),
  .flushing  (flushing)
);

// File: tb/tb_wta_lr_disparity.sv
module tb_wta_lr_disparity;
  localparam int ND  = 8;
  localparam int CWB = 8;
  localparam int LM  = 64;
  localparam int DW  = wta_lr_pkg::disp_bits(ND);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic [ND*CWB-1:0] in_cost = '0;
  logic              out_valid, out_ok;
  logic [DW-1:0]     out_disp;

  int n_cmp = 0, n_bad = 0;
  int costs [0:63][0:7];
  int exp_d [0:63];
  int exp_ok[0:63];
  int got_d [$];
  int got_ok[$];
  bit done = 0;

  always #2 clk = ~clk;

  wta_lr_disparity #(.NDISP(ND), .CW(CWB), .LINE_MAX(LM)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol), .in_eol(in_eol),
    .in_cost(in_cost), .out_valid(out_valid), .out_disp(out_disp), .out_ok(out_ok));

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      got_d.push_back(int'(out_disp));
      got_ok.push_back(int'(out_ok));
    end
  end

  task automatic check(input bit cond, input string req, input int act, input int expv);
    n_cmp++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic void model(input int w);
    int dm[0:63];
    for (int x = 0; x < w; x++) begin
      int b = costs[x][0];
      exp_d[x] = 0;
      for (int d = 1; d < ND; d++)
        if (costs[x][d] < b) begin b = costs[x][d]; exp_d[x] = d; end
    end
    for (int xp = 0; xp < w; xp++) begin
      int b = 1 << 30;
      dm[xp] = 0;
      for (int d = 0; d < ND; d++)
        if (xp + d < w && costs[xp+d][d] < b) begin b = costs[xp+d][d]; dm[xp] = d; end
    end
    for (int x = 0; x < w; x++) begin
      int db = exp_d[x];
      exp_ok[x] = 0;
      if (x >= db) begin
        int df = db - dm[x-db];
        if (df < 0) df = -df;
        exp_ok[x] = (df <= 1) ? 1 : 0;
      end
    end
  endfunction

  // mode 0: wide random, 1: narrow random (ties), 2: disparity profile, 3: flat
  function automatic void fill(input int w, input int mode);
    int t = $urandom % ND;
    for (int x = 0; x < w; x++) begin
      if (mode == 2 && ($urandom % 4) == 0) begin
        t = t + (($urandom % 2) == 0 ? 1 : -1);
        if (t < 0) t = 0;
        if (t > ND - 1) t = ND - 1;
      end
      for (int d = 0; d < ND; d++) begin
        case (mode)
          0: costs[x][d] = $urandom % 256;
          1: costs[x][d] = $urandom % 4;
          2: costs[x][d] = (d == t) ? $urandom % 6 : 40 + $urandom % 50;
          default: costs[x][d] = 17;
        endcase
      end
    end
  endfunction

  task automatic run_line(input int w, input int mode, input int gap_pct, input string tag);
    fill(w, mode);
    model(w);
    got_d.delete();
    got_ok.delete();
    for (int x = 0; x < w; x++) begin
      while (($urandom % 100) < gap_pct) begin
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sol   = (x == 0);
      in_eol   = (x == w - 1);
      for (int d = 0; d < ND; d++) in_cost[d*CWB +: CWB] = CWB'(costs[x][d]);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
    repeat (ND + 3 + ($urandom % 3)) @(negedge clk);
    check(got_d.size() == w, {"R5 result count ", tag}, got_d.size(), w);
    for (int i = 0; i < w && i < got_d.size(); i++) begin
      if (exp_ok[i] == 1) begin
        check(got_d[i] == exp_d[i], {"R1 accepted disparity ", tag}, got_d[i], exp_d[i]);
        check(got_ok[i] == 1, {"R3 with R2 match ok flag ", tag}, got_ok[i], 1);
      end else begin
        check(got_d[i] == ND, {"R4 reserved code ", tag}, got_d[i], ND);
        check(got_ok[i] == 0, {"R3 with R2 reject flag ", tag}, got_ok[i], 0);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R6 valid in reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R6 valid after reset", int'(out_valid), 0);
    check(out_ok == 1'b0, "R6 ok after reset", int'(out_ok), 0);
    check(out_disp == '0, "R6 disp after reset", int'(out_disp), 0);

    // Directed corners
    run_line(1, 3, 0, "R7 single pixel flat");
    run_line(ND - 1, 1, 0, "short narrow");
    run_line(ND, 2, 0, "profile exact ndisp");
    run_line(20, 3, 0, "flat ties");
    run_line(1, 0, 0, "single pixel random");
    run_line(60, 2, 0, "long profile");
    run_line(40, 2, 30, "R7 profile with gaps");

    // Constrained random lines
    for (int n = 0; n < 80; n++) begin
      int w = 1 + ($urandom % 48);
      int m = $urandom % 3;
      int g = (($urandom % 2) == 0) ? 0 : 25;
      run_line(w, m, g, (g != 0) ? "R7 random with gaps" : "random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule